// File: doc/BRIEF.md
# JTAG Programming-Mode Entry Sequencer

This block is a host-side JTAG master that drives the test clock, mode-select and data-in lines of a target's TAP controller. It replays one fixed scan script. The script puts the target into its serial programming mode: a TAP reset, a walk into Select-DR-Scan, an instruction scan of 0x2, a 4-bit data scan of 0x2, and an instruction scan of 0xC. After each Update state the script goes straight back to Select-DR-Scan, so the TAP never returns to Run-Test/Idle between scans.

The test clock is the system clock divided by an even ratio, with a 50 % duty cycle. The block drives the mode-select and data-in lines only on falling test-clock edges, and it samples the target's data-out line on rising edges. A single start pulse runs the whole script. Busy stays high while the script runs, and done pulses once at the end. The data-out bits shifted back during each of the three scans are kept in three separate output registers, for use by the host logic that follows.

Top module: `jtag_entry_seq`

## Requirements
- R1: While `rst` is high and after it is released, `tck`, `tdi`, `busy`, `done` and the three capture outputs are 0, and `tms` is 1.
- R2: While `busy` is high, `tck` is a square wave with a period of DIV_RATIO system cycles. It goes high DIV_RATIO/2 cycles after the start cycle. While `busy` is low, `tck` is low.
- R3: `tms` and `tdi` change only in the cycle in which `tck` falls, or in the cycle in which a start is accepted (this loads the first script value).
- R4: The script opens with 5 test-clock pulses with `tms`=1, followed by one pulse with `tms`=0 and one pulse with `tms`=1.
- R5: The first scan uses `tms` values 1,0,0. It then shifts 4 bits of 0x2, least significant bit first, with `tms`=1 only on the last bit, and ends with one `tms`=1 pulse into Update-IR.
- R6: One `tms`=1 pulse leads from Update-IR to Select-DR-Scan. The data scan then uses `tms` values 0,0, shifts 4 bits of 0x2 least significant bit first with `tms`=1 on the last bit, and ends with `tms`=1. The TAP enters Run-Test/Idle only once per run.
- R7: One `tms`=1 pulse leads from Update-DR to Select-DR-Scan. A second instruction scan, shaped like R5, then loads 0xC.
- R8: `tdi` is 0 on every test-clock pulse that is not a shift pulse.
- R9: On the rising `tck` edge of the k-th shift pulse of a scan (k = 0..3), `tdo` is stored in bit k of that scan's register: `tdo_ir_first`, `tdo_dr` or `tdo_ir_second`.
- R10: After the 32nd pulse falls, `busy` drops and `done` is high for exactly one cycle.
- R11: A start that arrives while `busy` is high has no effect on the pulse train or the end time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the script when idle |
| tdo | input | 1 | Target data out |
| tck | output | 1 | Test clock to target |
| tms | output | 1 | Test mode select to target |
| tdi | output | 1 | Test data in to target |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle end-of-script pulse |
| tdo_ir_first | output | IR_BITS | TDO bits from the first instruction scan |
| tdo_dr | output | DR_BITS | TDO bits from the data scan |
| tdo_ir_second | output | IR_BITS | TDO bits from the second instruction scan |

## Verification
The bench builds the block with DIV_RATIO = 6. Each half period of `tck` then spans three system cycles, which exercises the divider count, not just a toggle on every cycle. It also means the bench can check that `tms` and `tdi` hold steady across the cycles of the high phase. The register lengths and the script values keep their default settings, which gives the 32-pulse script. A behavioural TAP model in the bench follows the pulse train and returns different capture patterns on two runs. This lets the bench check the LSB-first bit order, both in the values that reach the target's registers and in the bits captured from `tdo`. The bench also sends a second start in the middle of a run and holds start high for several cycles, to check that neither one changes the run.

// File: rtl/jtag_entry_pkg.sv
package jtag_entry_pkg;

    localparam logic [1:0] SCAN_IR_FIRST  = 2'd0;
    localparam logic [1:0] SCAN_DR        = 2'd1;
    localparam logic [1:0] SCAN_IR_SECOND = 2'd2;

    typedef struct packed {
        logic       tms;
        logic       tdi;
        logic       shift;
        logic [1:0] scan;
        logic [4:0] bit_no;
    } jtag_step_t;

    // Number of test-clock pulses in the whole script
    function automatic int unsigned script_len(input int unsigned rst_pulses,
                                               input int unsigned ir_bits,
                                               input int unsigned dr_bits);
        return rst_pulses + 2 + 2 * (ir_bits + 4) + (dr_bits + 3) + 2;
    endfunction

    // One pulse inside a scan; p counts from the Select state (IR) or Capture entry (DR)
    function automatic jtag_step_t scan_step(input int unsigned p,
                                             input int unsigned len,
                                             input logic [31:0] val,
                                             input logic is_ir,
                                             input logic [1:0] scan);
        jtag_step_t  s;
        int unsigned q;
        s      = '0;
        s.scan = scan;
        if (is_ir && p == 0) begin
            s.tms = 1'b1;
            return s;
        end
        q = is_ir ? p - 1 : p;
        if (q < 2) begin
            s.tms = 1'b0;
        end else if (q < len + 2) begin
            s.shift  = 1'b1;
            s.bit_no = 5'(q - 2);
            s.tdi    = val[q-2];
            s.tms    = (q == len + 1);
        end else begin
            s.tms = 1'b1;
        end
        return s;
    endfunction

    // Full script: reset, walk, IR scan, link, DR scan, link, IR scan
    function automatic jtag_step_t script_step(input int unsigned idx,
                                               input int unsigned rst_pulses,
                                               input int unsigned ir_bits,
                                               input int unsigned dr_bits,
                                               input logic [31:0] ir_a,
                                               input logic [31:0] dr_v,
                                               input logic [31:0] ir_b);
        jtag_step_t  s;
        int unsigned p;
        int unsigned ir_len;
        int unsigned dr_len;
        s      = '0;
        p      = idx;
        ir_len = ir_bits + 4;
        dr_len = dr_bits + 3;
        if (p < rst_pulses) begin
            s.tms = 1'b1;
            return s;
        end
        p = p - rst_pulses;
        if (p < 2) begin
            s.tms = (p == 1);
            return s;
        end
        p = p - 2;
        if (p < ir_len) return scan_step(p, ir_bits, ir_a, 1'b1, SCAN_IR_FIRST);
        p = p - ir_len;
        if (p == 0) begin
            s.tms = 1'b1;
            return s;
        end
        p = p - 1;
        if (p < dr_len) return scan_step(p, dr_bits, dr_v, 1'b0, SCAN_DR);
        p = p - dr_len;
        if (p == 0) begin
            s.tms = 1'b1;
            return s;
        end
        p = p - 1;
        return scan_step(p, ir_bits, ir_b, 1'b1, SCAN_IR_SECOND);
    endfunction

endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
    parameter int unsigned DIV_RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned HALF  = DIV_RATIO / 2;
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             tck_q;
    logic             edge_now;

    assign edge_now = run_i && (cnt_q == CNT_W'(HALF - 1));
    assign rise_o   = edge_now && !tck_q;
    assign fall_o   = edge_now && tck_q;
    assign tck_o    = tck_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (edge_now) begin
            cnt_q <= '0;
            tck_q <= !tck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TCK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !tck_q); // R2
    AST_TCK_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tck_q != $past(tck_q)) |-> ($past(cnt_q) == CNT_W'(HALF - 1))); // R2

endmodule

// File: rtl/jtag_script_ctl.sv
module jtag_script_ctl
    import jtag_entry_pkg::*;
#(
    parameter int unsigned RESET_PULSES = 5,
    parameter int unsigned IR_BITS      = 4,
    parameter int unsigned DR_BITS      = 4,
    parameter int unsigned IR_FIRST     = 2,
    parameter int unsigned DR_VALUE     = 2,
    parameter int unsigned IR_SECOND    = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       tms_o,
    output logic       tdi_o,
    output logic       cap_en_o,
    output logic [1:0] cap_scan_o,
    output logic [4:0] cap_bit_o
);
    localparam int unsigned TOTAL = script_len(RESET_PULSES, IR_BITS, DR_BITS);
    localparam int unsigned IDX_W = $clog2(TOTAL);
    localparam int unsigned LAST  = TOTAL - 1;

    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic             done_q;
    logic             tms_q;
    logic             tdi_q;
    int unsigned      look_idx;
    jtag_step_t       step;

    // Rise and fall never coincide: look at the current pulse while waiting
    // for a rise, at the following one when a fall loads new pin values.
    always_comb begin
        if (!busy_q)      look_idx = 0;
        else if (fall_i)  look_idx = int'(idx_q) + 1;
        else              look_idx = int'(idx_q);
        step = script_step(look_idx, RESET_PULSES, IR_BITS, DR_BITS,
                           32'(IR_FIRST), 32'(DR_VALUE), 32'(IR_SECOND));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            tms_q  <= 1'b1;
            tdi_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start_i) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                tms_q  <= step.tms;
                tdi_q  <= step.tdi;
            end else if (busy_q && fall_i) begin
                if (idx_q == IDX_W'(LAST)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    tms_q <= step.tms;
                    tdi_q <= step.tdi;
                end
            end
        end
    end

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign tms_o      = tms_q;
    assign tdi_o      = tdi_q;
    assign cap_en_o   = busy_q && rise_i && step.shift;
    assign cap_scan_o = step.scan;
    assign cap_bit_o  = step.bit_no;

    AST_PINS_MOVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        ((tms_q != $past(tms_q)) || (tdi_q != $past(tdi_q)))
            |-> ($past(fall_i) || $past(start_i && !busy_q))); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && $past(busy_q))); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && !fall_i) |=> (busy_q && $stable(idx_q))); // R11

endmodule

// File: rtl/jtag_tdo_capture.sv
module jtag_tdo_capture
    import jtag_entry_pkg::*;
#(
    parameter int unsigned IR_BITS = 4,
    parameter int unsigned DR_BITS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en_i,
    input  logic [1:0]         cap_scan_i,
    input  logic [4:0]         cap_bit_i,
    input  logic               tdo_i,
    output logic [IR_BITS-1:0] ir_first_o,
    output logic [DR_BITS-1:0] dr_o,
    output logic [IR_BITS-1:0] ir_second_o
);
    logic [IR_BITS-1:0] ir_first_q;
    logic [DR_BITS-1:0] dr_q;
    logic [IR_BITS-1:0] ir_second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_first_q  <= '0;
            dr_q        <= '0;
            ir_second_q <= '0;
        end else if (cap_en_i) begin
            case (cap_scan_i)
                SCAN_IR_FIRST: begin
                    for (int k = 0; k < int'(IR_BITS); k++)
                        if (cap_bit_i == 5'(k)) ir_first_q[k] <= tdo_i;
                end
                SCAN_DR: begin
                    for (int k = 0; k < int'(DR_BITS); k++)
                        if (cap_bit_i == 5'(k)) dr_q[k] <= tdo_i;
                end
                SCAN_IR_SECOND: begin
                    for (int k = 0; k < int'(IR_BITS); k++)
                        if (cap_bit_i == 5'(k)) ir_second_q[k] <= tdo_i;
                end
                default: ;
            endcase
        end
    end

    assign ir_first_o  = ir_first_q;
    assign dr_o        = dr_q;
    assign ir_second_o = ir_second_q;

    AST_CAPTURE_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cap_en_i |-> (cap_scan_i != 2'd3)); // R9

endmodule

// File: rtl/jtag_entry_seq.sv
module jtag_entry_seq #(
    parameter int unsigned DIV_RATIO    = 4,
    parameter int unsigned RESET_PULSES = 5,
    parameter int unsigned IR_BITS      = 4,
    parameter int unsigned DR_BITS      = 4,
    parameter int unsigned IR_FIRST     = 2,
    parameter int unsigned DR_VALUE     = 2,
    parameter int unsigned IR_SECOND    = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               tdo,
    output logic               tck,
    output logic               tms,
    output logic               tdi,
    output logic               busy,
    output logic               done,
    output logic [IR_BITS-1:0] tdo_ir_first,
    output logic [DR_BITS-1:0] tdo_dr,
    output logic [IR_BITS-1:0] tdo_ir_second
);
    logic       rise;
    logic       fall;
    logic       cap_en;
    logic [1:0] cap_scan;
    logic [4:0] cap_bit;

    jtag_tck_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run_i (busy),
        .tck_o (tck),
        .rise_o(rise),
        .fall_o(fall)
    );

    jtag_script_ctl #(
        .RESET_PULSES(RESET_PULSES),
        .IR_BITS     (IR_BITS),
        .DR_BITS     (DR_BITS),
        .IR_FIRST    (IR_FIRST),
        .DR_VALUE    (DR_VALUE),
        .IR_SECOND   (IR_SECOND)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .rise_i    (rise),
        .fall_i    (fall),
        .busy_o    (busy),
        .done_o    (done),
        .tms_o     (tms),
        .tdi_o     (tdi),
        .cap_en_o  (cap_en),
        .cap_scan_o(cap_scan),
        .cap_bit_o (cap_bit)
    );

    jtag_tdo_capture #(.IR_BITS(IR_BITS), .DR_BITS(DR_BITS)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .cap_en_i   (cap_en),
        .cap_scan_i (cap_scan),
        .cap_bit_i  (cap_bit),
        .tdo_i      (tdo),
        .ir_first_o (tdo_ir_first),
        .dr_o       (tdo_dr),
        .ir_second_o(tdo_ir_second)
    );

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck); // R2
    AST_CAPTURE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (busy && !tck)); // R9

endmodule

// File: tb/jtag_entry_seq_bench.sv
module jtag_entry_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 6;
    localparam int HALF       = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tdo = 1'b0;
    logic tck, tms, tdi, busy, done;
    logic [3:0] tdo_ir_first, tdo_dr, tdo_ir_second;

    always #(CLK_PERIOD / 2) clk = !clk;

    jtag_entry_seq #(.DIV_RATIO(DIV)) u_jtag_entry_seq (
        .clk(clk), .rst(rst), .start(start), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
        .tdo_ir_first(tdo_ir_first), .tdo_dr(tdo_dr), .tdo_ir_second(tdo_ir_second)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- expected script ----------------
    bit exp_tms[$];
    bit exp_tdi[$];

    task automatic put(input bit m, input bit d);
        exp_tms.push_back(m);
        exp_tdi.push_back(d);
    endtask

    task automatic put_scan(input bit is_ir, input logic [3:0] v);
        if (is_ir) put(1, 0);
        put(0, 0);
        put(0, 0);
        for (int k = 0; k < 4; k++) put(k == 3, v[k]);
        put(1, 0);
    endtask

    function automatic string seg_tag(input int n);
        if (n < 7)  return "R4";
        if (n < 15) return "R5";
        if (n < 23) return "R6";
        return "R7";
    endfunction

    // ---------------- cycle reference model ----------------
    bit m_busy, m_done, m_tck, m_tms, m_tdi;
    int m_j;
    int m_n;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_tck = 0; m_tms = 1; m_tdi = 0; m_j = 0; m_n = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_j = 0; m_n = 0; m_tck = 0;
                    m_tms = exp_tms[0]; m_tdi = exp_tdi[0];
                end
            end else begin
                m_j++;
                m_tck = ((m_j / HALF) % 2) == 1;
                if (m_j % (2 * HALF) == 0) begin
                    m_n = m_j / (2 * HALF);
                    if (m_n == exp_tms.size()) begin
                        m_busy = 0; m_done = 1; m_tck = 0;
                    end else begin
                        m_tms = exp_tms[m_n]; m_tdi = exp_tdi[m_n];
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(tck == m_tck, "R2 tck", tck, m_tck);
            chk(busy == m_busy, "R10 busy", busy, m_busy);
            chk(done == m_done, "R10 done", done, m_done);
            chk(tms == m_tms, {"R3 ", seg_tag(m_n), " tms"}, tms, m_tms);
            chk(tdi == m_tdi, {"R3 ", seg_tag(m_n), " tdi"}, tdi, m_tdi);
        end
    end

    // ---------------- behavioural target TAP ----------------
    typedef enum logic [3:0] {
        T_RESET, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR, T_UPDR,
        T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPIR
    } tap_t;

    function automatic tap_t tap_next(input tap_t s, input logic m);
        case (s)
            T_RESET: return m ? T_RESET : T_IDLE;
            T_IDLE:  return m ? T_SELDR : T_IDLE;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SHDR;
            T_SHDR:  return m ? T_EX1DR : T_SHDR;
            T_EX1DR: return m ? T_UPDR  : T_PAUDR;
            T_PAUDR: return m ? T_EX2DR : T_PAUDR;
            T_EX2DR: return m ? T_UPDR  : T_SHDR;
            T_UPDR:  return m ? T_SELDR : T_IDLE;
            T_SELIR: return m ? T_RESET : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SHIR;
            T_SHIR:  return m ? T_EX1IR : T_SHIR;
            T_EX1IR: return m ? T_UPIR  : T_PAUIR;
            T_PAUIR: return m ? T_EX2IR : T_PAUIR;
            T_EX2IR: return m ? T_UPIR  : T_SHIR;
            default: return m ? T_SELDR : T_IDLE;
        endcase
    endfunction

    tap_t ts = T_RESET;
    tap_t nx;
    logic [3:0] ir_sr = '0;
    logic [3:0] dr_sr = '0;
    logic [3:0] cap_ir_a, cap_ir_b, cap_dr;
    logic [3:0] ir_log[$];
    logic [3:0] dr_log[$];
    int ir_caps = 0;
    int rti_count = 0;
    int pulses = 0;

    always @(posedge tck) begin
        pulses++;
        if (ts != T_SHIR && ts != T_SHDR) chk(tdi == 1'b0, "R8 tdi outside shift", tdi, 0);
        case (ts)
            T_CAPIR: begin
                ir_sr <= (ir_caps == 0) ? cap_ir_a : cap_ir_b;
                ir_caps++;
            end
            T_CAPDR: dr_sr <= cap_dr;
            T_SHIR:  ir_sr <= {tdi, ir_sr[3:1]};
            T_SHDR:  dr_sr <= {tdi, dr_sr[3:1]};
            default: ;
        endcase
        nx = tap_next(ts, tms);
        if (nx == T_UPIR) ir_log.push_back(ir_sr);
        if (nx == T_UPDR) dr_log.push_back(dr_sr);
        if (nx == T_IDLE) rti_count++;
        if (nx == T_RESET) ir_caps = 0;
        ts <= nx;
    end

    always @(negedge tck) begin
        if (ts == T_SHIR)      tdo <= ir_sr[0];
        else if (ts == T_SHDR) tdo <= dr_sr[0];
        else                   tdo <= 1'b0;
    end

    // ---------------- stimulus ----------------
    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic run(input logic [3:0] ira, input logic [3:0] drv, input logic [3:0] irb,
                       input bit mid_start, input int hold);
        int guard;
        cap_ir_a = ira; cap_dr = drv; cap_ir_b = irb;
        ir_log.delete(); dr_log.delete();
        rti_count = 0; pulses = 0;
        start = 1'b1;
        repeat (hold) @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (40) @(negedge clk);
            start = 1'b1;               // R11: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R10 done reached", done, 1);
        chk(busy == 1'b0, "R10 busy low at done", busy, 0);
        chk(tck == 1'b0, "R2 tck low at end", tck, 0);
        chk(pulses == exp_tms.size(), "R10 pulse count", pulses, exp_tms.size());
        chk(ts == T_UPIR, "R7 final TAP state", ts, T_UPIR);
        chk(rti_count == 1, "R6 idle visits", rti_count, 1);
        chk(ir_log.size() == 2, "R5 IR updates", ir_log.size(), 2);
        if (ir_log.size() == 2) begin
            chk(ir_log[0] == 4'h2, "R5 first IR value", ir_log[0], 4'h2);
            chk(ir_log[1] == 4'hC, "R7 second IR value", ir_log[1], 4'hC);
        end
        chk(dr_log.size() == 1, "R6 DR updates", dr_log.size(), 1);
        if (dr_log.size() == 1) chk(dr_log[0] == 4'h2, "R6 DR value", dr_log[0], 4'h2);
        chk(tdo_ir_first == ira, "R9 tdo_ir_first", tdo_ir_first, ira);
        chk(tdo_dr == drv, "R9 tdo_dr", tdo_dr, drv);
        chk(tdo_ir_second == irb, "R9 tdo_ir_second", tdo_ir_second, irb);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    initial begin
        for (int k = 0; k < 5; k++) put(1, 0);
        put(0, 0);
        put(1, 0);
        put_scan(1, 4'h2);
        put(1, 0);
        put_scan(0, 4'h2);
        put(1, 0);
        put_scan(1, 4'hC);

        repeat (3) @(negedge clk);
        chk(tck == 1'b0 && tdi == 1'b0, "R1 tck/tdi in reset", {tck, tdi}, 0);
        chk(tms == 1'b1, "R1 tms in reset", tms, 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        chk({tdo_ir_first, tdo_dr, tdo_ir_second} == 12'h0, "R1 captures in reset",
            {tdo_ir_first, tdo_dr, tdo_ir_second}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && tck == 1'b0, "R1 idle after reset", {busy, tck}, 0);

        run(4'h5, 4'h6, 4'h9, 1'b1, 1);
        repeat (5) @(negedge clk);
        run(4'hA, 4'hC, 4'h3, 1'b0, 3);
        repeat (4) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL R10 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule